// File: doc/BRIEF.md
# Destination address filter

This block sits behind a receive MAC and gives a keep-or-drop verdict on each incoming frame from its 48-bit destination address alone. The receive path presents the address with a one-cycle valid strobe. One clock later the block raises a done strobe together with the accept flag. The flag then holds until the next address is judged.

The verdict comes from a fixed chain of rules, evaluated in this order:

1. A promiscuous override accepts everything.
2. The all-ones broadcast address is either passed or blocked, as configured.
3. A 64-bit hash table accepts addresses whose folded 6-bit index selects a set bit. Group (multicast) and individual (unicast) addresses have separate enables for this lookup.
4. A set of exact-match address slots accepts any address equal to one of them.

An address that no rule accepts is dropped. Frame reception and the frame check sequence are handled elsewhere.

Top module: `dest_addr_filter`

## Requirements
- R1: With `cfg_promisc` high, every address is accepted, including a broadcast while `cfg_bcast_reject` is high.
- R2: With `cfg_promisc` low and `cfg_bcast_reject` low, the all-ones address is accepted.
- R3: With `cfg_promisc` low and `cfg_bcast_reject` high, the all-ones address is rejected, even if the hash table or a slot would accept it.
- R4: An address is a group address when its first byte (`dest_addr[7:0]`) equals 0x01. Only `cfg_mcast_hash_en` enables the hash lookup for group addresses, and only `cfg_ucast_hash_en` enables it for all other addresses.
- R5: Hash index bit i (i = 0..5) is the XOR of `dest_addr` bits i, i+6, i+12, i+18, i+24, i+30, i+36 and i+42. Byte k of the address, where byte 0 is received first, occupies `dest_addr[8k+7:8k]`.
- R6: An index below 32 selects that bit of `hash_lo`, and an index of 32 or more selects bit (index-32) of `hash_hi`. When the lookup is enabled, a set selected bit accepts the address.
- R7: Slot s holds address bytes 0..3 in `slot_lo[32s+31:32s]` (byte 0 in the lowest 8 bits) and bytes 4..5 in `slot_hi[16s+15:16s]`. An address equal to any slot in all 48 bits is accepted when R1 to R3 have not already decided.
- R8: An address that none of the rules R1, R2, R6 or R7 accepts is rejected.
- R9: `decision_done` is high exactly in the cycle after each cycle with `addr_valid` high, and `frame_accept` carries that cycle's verdict. When `addr_valid` is low, `frame_accept` keeps its value.
- R10: While `rst` is high, and in the first cycle after it, `decision_done` and `frame_accept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_valid | input | 1 | Destination address is present this cycle |
| dest_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| cfg_promisc | input | 1 | Accept every address |
| cfg_bcast_reject | input | 1 | Drop the all-ones address |
| cfg_mcast_hash_en | input | 1 | Hash lookup for group addresses |
| cfg_ucast_hash_en | input | 1 | Hash lookup for individual addresses |
| hash_lo | input | 32 | Hash table entries 0..31 |
| hash_hi | input | 32 | Hash table entries 32..63 |
| slot_lo | input | 32*NUM_SLOTS | Slot address bytes 0..3, one word per slot |
| slot_hi | input | 16*NUM_SLOTS | Slot address bytes 4..5, one half-word per slot |
| decision_done | output | 1 | Verdict valid strobe |
| frame_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
Several properties are checked on every cycle, relating each strobe to the verdict that follows it:

- the one-cycle strobe timing and the holding of the flag between verdicts;
- the promiscuous override;
- both broadcast outcomes;
- acceptance on a slot hit;
- rejection when every hash enable is off and no slot matches.

The XOR fold, the split of the hash table into a low and a high word, and the group/individual choice of enable are not checked by any property. Only the bench can show them: directed addresses land on known indices, and a pseudo-random sweep is compared with a model written from the requirements. Reset in the middle of a run and back-to-back strobes are also exercised only by the bench.

// File: rtl/dest_filter_pkg.sv
package dest_filter_pkg;

    localparam int MAC_W        = 48;
    localparam int HASH_IDX_W   = 6;
    localparam int HASH_TAPS    = MAC_W / HASH_IDX_W;
    localparam int HASH_WORD_W  = 1 << (HASH_IDX_W - 1);
    localparam int SLOT_LO_W    = 32;
    localparam int SLOT_HI_W    = MAC_W - SLOT_LO_W;
    localparam logic [7:0] GROUP_MARK = 8'h01;

    typedef logic [MAC_W-1:0]      mac_addr_t;
    typedef logic [HASH_IDX_W-1:0] hash_idx_t;

    typedef struct packed {
        logic uc_hash_en;
        logic mc_hash_en;
        logic bcast_reject;
        logic promisc;
    } filter_cfg_t;

    typedef enum logic [2:0] {
        RULE_NONE        = 3'd0,
        RULE_PROMISC     = 3'd1,
        RULE_BCAST_PASS  = 3'd2,
        RULE_BCAST_BLOCK = 3'd3,
        RULE_HASH        = 3'd4,
        RULE_SLOT        = 3'd5
    } rule_e;

    typedef struct packed {
        logic done;
        logic accept;
    } verdict_t;

    function automatic logic is_broadcast(input mac_addr_t a);
        return &a;
    endfunction

    function automatic logic is_group_addr(input mac_addr_t a);
        return a[7:0] == GROUP_MARK;
    endfunction

    function automatic logic rule_keeps(input rule_e r);
        return (r == RULE_PROMISC) || (r == RULE_BCAST_PASS) ||
               (r == RULE_HASH)    || (r == RULE_SLOT);
    endfunction

endpackage

// File: rtl/daf_hash_lookup.sv
module daf_hash_lookup
    import dest_filter_pkg::*;
(
    input  mac_addr_t                addr,
    input  logic [HASH_WORD_W-1:0]   table_lo,
    input  logic [HASH_WORD_W-1:0]   table_hi,
    output logic                     hit
);

    hash_idx_t              idx;
    logic [HASH_WORD_W-1:0] word_sel;

    // Each index bit folds one tap from every 6-bit slice of the address.
    for (genvar i = 0; i < HASH_IDX_W; i++) begin : g_idx
        logic [HASH_TAPS-1:0] taps;
        for (genvar k = 0; k < HASH_TAPS; k++) begin : g_tap
            assign taps[k] = addr[i + HASH_IDX_W * k];
        end
        assign idx[i] = ^taps;
    end

    // Top index bit picks the word, the rest pick the bit within it.
    assign word_sel = idx[HASH_IDX_W-1] ? table_hi : table_lo;
    assign hit      = word_sel[idx[HASH_IDX_W-2:0]];

endmodule

// File: rtl/daf_exact_match.sv
module daf_exact_match
    import dest_filter_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  mac_addr_t                      addr,
    input  logic [NUM_SLOTS*SLOT_LO_W-1:0] slot_lo,
    input  logic [NUM_SLOTS*SLOT_HI_W-1:0] slot_hi,
    output logic                           any_hit
);

    logic [NUM_SLOTS-1:0] hit_vec;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        mac_addr_t slot_addr;
        assign slot_addr  = {slot_hi[s*SLOT_HI_W +: SLOT_HI_W],
                             slot_lo[s*SLOT_LO_W +: SLOT_LO_W]};
        assign hit_vec[s] = (slot_addr == addr);
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/daf_rule_chain.sv
module daf_rule_chain
    import dest_filter_pkg::*;
(
    input  filter_cfg_t cfg,
    input  mac_addr_t   addr,
    input  logic        hash_hit,
    input  logic        slot_hit,
    output rule_e       rule
);

    logic hash_enabled;

    assign hash_enabled = is_group_addr(addr) ? cfg.mc_hash_en : cfg.uc_hash_en;

    // Strict priority: override, broadcast, hash, slots, default drop.
    always_comb begin
        if (cfg.promisc) begin
            rule = RULE_PROMISC;
        end else if (is_broadcast(addr)) begin
            rule = cfg.bcast_reject ? RULE_BCAST_BLOCK : RULE_BCAST_PASS;
        end else if (hash_enabled && hash_hit) begin
            rule = RULE_HASH;
        end else if (slot_hit) begin
            rule = RULE_SLOT;
        end else begin
            rule = RULE_NONE;
        end
    end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import dest_filter_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           addr_valid,
    input  logic [MAC_W-1:0]               dest_addr,
    input  logic                           cfg_promisc,
    input  logic                           cfg_bcast_reject,
    input  logic                           cfg_mcast_hash_en,
    input  logic                           cfg_ucast_hash_en,
    input  logic [HASH_WORD_W-1:0]         hash_lo,
    input  logic [HASH_WORD_W-1:0]         hash_hi,
    input  logic [NUM_SLOTS*SLOT_LO_W-1:0] slot_lo,
    input  logic [NUM_SLOTS*SLOT_HI_W-1:0] slot_hi,
    output logic                           decision_done,
    output logic                           frame_accept
);

    filter_cfg_t cfg;
    logic        hash_hit;
    logic        slot_hit;
    rule_e       rule;
    verdict_t    verdict_q;

    assign cfg = '{uc_hash_en:   cfg_ucast_hash_en,
                   mc_hash_en:   cfg_mcast_hash_en,
                   bcast_reject: cfg_bcast_reject,
                   promisc:      cfg_promisc};

    daf_hash_lookup u_hash (
        .addr     (dest_addr),
        .table_lo (hash_lo),
        .table_hi (hash_hi),
        .hit      (hash_hit)
    );

    daf_exact_match #(.NUM_SLOTS(NUM_SLOTS)) u_exact (
        .addr    (dest_addr),
        .slot_lo (slot_lo),
        .slot_hi (slot_hi),
        .any_hit (slot_hit)
    );

    daf_rule_chain u_chain (
        .cfg      (cfg),
        .addr     (dest_addr),
        .hash_hit (hash_hit),
        .slot_hit (slot_hit),
        .rule     (rule)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.done <= addr_valid;
            if (addr_valid) begin
                verdict_q.accept <= rule_keeps(rule);
            end
        end
    end

    assign decision_done = verdict_q.done;
    assign frame_accept  = verdict_q.accept;

endmodule

// File: rtl/daf_checker.sv
module daf_checker
    import dest_filter_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           addr_valid,
    input logic [MAC_W-1:0]               dest_addr,
    input logic                           cfg_promisc,
    input logic                           cfg_bcast_reject,
    input logic                           cfg_mcast_hash_en,
    input logic                           cfg_ucast_hash_en,
    input logic [NUM_SLOTS*SLOT_LO_W-1:0] slot_lo,
    input logic [NUM_SLOTS*SLOT_HI_W-1:0] slot_hi,
    input logic                           decision_done,
    input logic                           frame_accept
);

    logic slot_seen;
    logic bcast_seen;

    always_comb begin
        slot_seen = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if ({slot_hi[s*SLOT_HI_W +: SLOT_HI_W], slot_lo[s*SLOT_LO_W +: SLOT_LO_W]} == dest_addr)
                slot_seen = 1'b1;
        end
    end

    assign bcast_seen = (dest_addr == {MAC_W{1'b1}});

    a_r1_promisc_accepts: assert property (@(posedge clk) disable iff (rst)
        addr_valid && cfg_promisc |=> decision_done && frame_accept);

    a_r2_bcast_passes: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !cfg_promisc && bcast_seen && !cfg_bcast_reject |=> frame_accept);

    a_r3_bcast_blocked: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !cfg_promisc && bcast_seen && cfg_bcast_reject |=> !frame_accept);

    a_r7_slot_accepts: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !cfg_promisc && !bcast_seen && slot_seen |=> frame_accept);

    a_r8_default_drop: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !cfg_promisc && !bcast_seen && !slot_seen &&
        !cfg_mcast_hash_en && !cfg_ucast_hash_en |=> !frame_accept);

    a_r9_done_after_valid: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> decision_done);

    a_r9_no_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> !decision_done);

    a_r9_accept_holds: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> $stable(frame_accept));

endmodule

bind dest_addr_filter daf_checker #(.NUM_SLOTS(NUM_SLOTS)) u_daf_checker (
    .clk               (clk),
    .rst               (rst),
    .addr_valid        (addr_valid),
    .dest_addr         (dest_addr),
    .cfg_promisc       (cfg_promisc),
    .cfg_bcast_reject  (cfg_bcast_reject),
    .cfg_mcast_hash_en (cfg_mcast_hash_en),
    .cfg_ucast_hash_en (cfg_ucast_hash_en),
    .slot_lo           (slot_lo),
    .slot_hi           (slot_hi),
    .decision_done     (decision_done),
    .frame_accept      (frame_accept)
);

// File: tb/tb_dest_addr_filter.sv
`timescale 1ns/1ps
module tb_dest_addr_filter;

    localparam int NSLOT = 4;
    localparam int NVEC  = 15;
    localparam int WDOG  = 100000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 addr_valid = 1'b0;
    logic [47:0]          dest_addr = '0;
    logic [3:0]           cfgv = '0;          // {ucast_en, mcast_en, bcast_reject, promisc}
    logic [31:0]          hash_lo = 32'h0000_0003;
    logic [31:0]          hash_hi = 32'h0000_0001;
    logic [NSLOT*32-1:0]  slot_lo;
    logic [NSLOT*16-1:0]  slot_hi;
    logic                 decision_done;
    logic                 frame_accept;

    int tests = 0;
    int fails = 0;

    logic [47:0] slot_addr [NSLOT];

    always #2 clk = ~clk;

    dest_addr_filter #(.NUM_SLOTS(NSLOT)) dut (
        .clk               (clk),
        .rst               (rst),
        .addr_valid        (addr_valid),
        .dest_addr         (dest_addr),
        .cfg_promisc       (cfgv[0]),
        .cfg_bcast_reject  (cfgv[1]),
        .cfg_mcast_hash_en (cfgv[2]),
        .cfg_ucast_hash_en (cfgv[3]),
        .hash_lo           (hash_lo),
        .hash_hi           (hash_hi),
        .slot_lo           (slot_lo),
        .slot_hi           (slot_hi),
        .decision_done     (decision_done),
        .frame_accept      (frame_accept)
    );

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_lo[s*32 +: 32] = slot_addr[s][31:0];
            slot_hi[s*16 +: 16] = slot_addr[s][47:32];
        end
    end

    // {cfg[3:0], addr[47:0], expected accept}
    localparam logic [52:0] VEC [NVEC] = '{
        {4'b0000, 48'hFFFF_FFFF_FFFF, 1'b1},   // R2 broadcast passes
        {4'b0010, 48'hFFFF_FFFF_FFFF, 1'b0},   // R3 broadcast blocked
        {4'b0011, 48'hFFFF_FFFF_FFFF, 1'b1},   // R1 override beats block
        {4'b0000, 48'h0000_0000_0001, 1'b0},   // R8 group, lookup off
        {4'b0100, 48'h0000_0000_0001, 1'b1},   // R4 R6 group index 1 set
        {4'b1000, 48'h0000_0000_0001, 1'b0},   // R4 individual enable ignored for group
        {4'b1000, 48'h0000_0000_0002, 1'b0},   // R5 index 2 clear
        {4'b1000, 48'h0000_0000_0041, 1'b1},   // R5 bits 0 and 6 cancel -> index 0 set
        {4'b1000, 48'h8000_0000_0000, 1'b1},   // R6 index 32 -> hash_hi bit 0
        {4'b0100, 48'h8000_0000_0001, 1'b0},   // R6 index 33 -> hash_hi bit 1 clear
        {4'b0000, 48'hBC9A_7856_3412, 1'b1},   // R7 slot 0
        {4'b0000, 48'hBD9A_7856_3412, 1'b0},   // R7 byte 5 differs
        {4'b0000, 48'hF0EE_DDCC_BBAA, 1'b1},   // R7 slot 3
        {4'b1010, 48'hFFFF_FFFF_FFFF, 1'b0},   // R3 blocked though index 0 is set
        {4'b0001, 48'h0000_0000_0002, 1'b1}    // R1 override
    };

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One strobe; returns after the verdict cycle, sampled at the negedge.
    task automatic judge(input logic [3:0] c, input logic [47:0] a);
        @(negedge clk);
        cfgv       = c;
        dest_addr  = a;
        addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    function automatic logic model(input logic [47:0] a, input logic [3:0] c);
        logic [5:0]  idx;
        logic [31:0] w;
        logic        grp;
        if (c[0]) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return !c[1];
        grp = (a[7:0] == 8'h01);
        if ((grp && c[2]) || (!grp && c[3])) begin
            idx = '0;
            for (int i = 0; i < 6; i++)
                for (int k = 0; k < 8; k++) begin
                    int n;
                    n = i + 6 * k;
                    idx[i] = idx[i] ^ a[(n / 8) * 8 + (n % 8)];
                end
            w = (idx >= 6'd32) ? hash_hi : hash_lo;
            if (w[idx % 32]) return 1'b1;
        end
        for (int s = 0; s < NSLOT; s++)
            if (a == slot_addr[s]) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9: actual no finish expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] lf;
        slot_addr[0] = 48'hBC9A_7856_3412;
        slot_addr[1] = 48'h0000_5E00_0102;
        slot_addr[2] = 48'h1111_2222_3344;
        slot_addr[3] = 48'hF0EE_DDCC_BBAA;

        // R10 reset state
        repeat (3) @(negedge clk);
        chk("R10 done in reset", {47'd0, decision_done}, 48'd0);
        chk("R10 accept in reset", {47'd0, frame_accept}, 48'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 done after reset", {47'd0, decision_done}, 48'd0);

        // vector table
        for (int n = 0; n < NVEC; n++) begin
            judge(VEC[n][52:49], VEC[n][48:1]);
            chk("R9 done strobe", {47'd0, decision_done}, 48'd1);
            chk($sformatf("R1-R8 table vector %0d", n), {47'd0, frame_accept}, {47'd0, VEC[n][0]});
        end

        // R9 hold: accept set, then idle with a rejecting address on the bus
        judge(4'b0000, 48'hBC9A_7856_3412);
        dest_addr = 48'h0000_0000_0002;
        @(negedge clk);
        chk("R9 done drops", {47'd0, decision_done}, 48'd0);
        @(negedge clk);
        chk("R9 accept held", {47'd0, frame_accept}, 48'd1);

        // R9 back-to-back strobes
        @(negedge clk);
        cfgv = 4'b0000; dest_addr = 48'hF0EE_DDCC_BBAA; addr_valid = 1'b1;
        @(negedge clk);
        chk("R9 b2b first done", {47'd0, decision_done}, 48'd1);
        chk("R9 b2b first accept", {47'd0, frame_accept}, 48'd1);
        dest_addr = 48'h0000_0000_0004;
        @(negedge clk);
        addr_valid = 1'b0;
        chk("R9 b2b second done", {47'd0, decision_done}, 48'd1);
        chk("R9 b2b second accept", {47'd0, frame_accept}, 48'd0);

        // R10 reset in the middle of a run
        judge(4'b0001, 48'h0000_0000_0004);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 mid-run accept", {47'd0, frame_accept}, 48'd0);
        chk("R10 mid-run done", {47'd0, decision_done}, 48'd0);
        rst = 1'b0;

        // pseudo-random sweep against the model (R4 R5 R6 R7 R8)
        hash_lo = 32'hA5C3_0F96;
        hash_hi = 32'h3C5A_F00F;
        lf = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 400; n++) begin
            logic [47:0] a;
            logic [3:0]  c;
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 7);
            lf = lf ^ (lf << 17);
            a = lf[47:0];
            c = lf[63:60];
            if (n % 4 == 1) a[7:0] = 8'h01;
            if (n % 9 == 2) a = slot_addr[n % NSLOT];
            if (n % 13 == 3) a = 48'hFFFF_FFFF_FFFF;
            judge(c, a);
            chk($sformatf("R5 R6 R7 sweep %0d", n), {47'd0, frame_accept}, {47'd0, model(a, c)});
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule